// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the feedback divider of an integer-N frequency synthesizer. It runs on the divided oscillator clock. Each divide cycle emits one comparison pulse `fp` every N = P·B + A input clocks. Inside, a dual-modulus stage divides by P+1 for the first A of its periods and by P for the rest. A main counter ends the cycle after B prescaler periods.

The lower modulus P is a power of two. The `mod_sel` input picks it: 2^PRE_LOG2 when low and twice that when high. With the default PRE_LOG2 = 5 the pair is 32/33 or 64/65. With PRE_LOG2 = 3 it is 8/9 or 16/17. The swallow count A uses PRE_LOG2+1 bits, giving a range of 0..63 or 0..15.

The presets and the modulus select are captured only when a divide cycle starts, so the software side may rewrite them at any time. Power-down freezes the divider where it stands. A counter-clear input holds it idle, so it starts a fresh cycle when released.

Top module: `swallow_div`

## Requirements
- R1: With B ≥ A, consecutive `fp` pulses are spaced by exactly P·B + A clock cycles. The first A prescaler periods of each cycle last P+1 clocks and the rest last P clocks.
- R2: P is 2^PRE_LOG2 when `mod_sel` is 0 and 2^(PRE_LOG2+1) when `mod_sel` is 1. With PRE_LOG2 = 5 the value of P is 32 or 64.
- R3: Only the low PRE_LOG2+1 bits of `a_preset` count. With PRE_LOG2 = 5, bit 6 of the 7-bit port has no effect on the ratio.
- R4: A `b_preset` value below 3 is used as 3.
- R5: `fp` is high for exactly one clock cycle per divide cycle.
- R6: `a_preset`, `b_preset` and `mod_sel` are sampled only at the start of a divide cycle. A change during a cycle leaves that cycle's length unchanged and applies from the next cycle.
- R7: After `rst` or `cnt_clr` is released, the first edge that sees both low (with `pwr_dn` low) starts a cycle. `fp` then rises on the (N+1)-th rising edge, counting that edge as the first.
- R8: While `pwr_dn` is high, every counter holds its value and `fp` stays low. A power-down of G clocks inside a cycle lengthens that cycle to exactly N + G clocks.
- R9: While `cnt_clr` is high, the divider is idle with `fp` low. On release it restarts as in R7, whatever point of the cycle it left.
- R10: While `rst` is high, `fp` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided oscillator clock; all counting is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mod_sel | input | 1 | Prescaler pair select: 0 gives P = 2^PRE_LOG2, 1 doubles it |
| a_preset | input | A_IN_W (7) | Swallow count A; bits above PRE_LOG2 are ignored |
| b_preset | input | B_W (11) | Main count B, 3..2047 |
| pwr_dn | input | 1 | Freeze all counting and keep `fp` low |
| cnt_clr | input | 1 | Hold the counters idle while high |
| fp | output | 1 | One-clock comparison pulse per divide cycle |

## Verification
The hardest conditions to reach from the ports depend on the stimulus landing inside a cycle, not at its edges. One is a power-down that freezes the counters partway through. The other is a preset rewrite made while the old cycle is still running. The bench aligns to an observed `fp` pulse and then counts a known number of clocks before each event. The expected span is therefore exact: N + G for a freeze, and the old N followed by the new one for a rewrite. A vector table covers the spacing for several A/B/modulus mixes. The mixes include A = B, A = 0, a large 4095 ratio, a masked top bit of A and B values of 0 and 1.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

    localparam int B_BITS      = 11;
    localparam int A_PORT_BITS = 7;
    localparam int B_FLOOR     = 3;
    localparam int PRE_LOG2_DEF = 5;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Per-cycle configuration captured at the start of a divide cycle.
    typedef struct packed {
        logic                   wide;
        logic [A_PORT_BITS-1:0] a;
        logic [B_BITS-1:0]      b;
    } cyc_cfg_t;

endpackage

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler #(
    parameter int PRE_LOG2 = 5
) (
    input  logic clk,
    input  logic clr,
    input  logic adv,
    input  logic wide_nx,
    input  logic swal_nx,
    output logic tc
);
    localparam int CW = PRE_LOG2 + 2;
    localparam logic [CW-1:0] BASE = CW'(1) << PRE_LOG2;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] modulus_m1;

    // Period length minus one: P-1 normally, P while swallowing.
    always_comb begin
        modulus_m1 = wide_nx ? (BASE << 1) : BASE;
        if (!swal_nx) begin
            modulus_m1 = modulus_m1 - CW'(1);
        end
    end

    assign tc = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= tc ? modulus_m1 : (cnt_q - CW'(1));
        end
    end

endmodule

// File: rtl/swdiv_counters.sv
module swdiv_counters
    import swdiv_pkg::*;
#(
    parameter int AW = A_PORT_BITS,
    parameter int BW = B_BITS
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          adv,
    input  logic          tc,
    input  logic          mod_sel,
    input  logic [AW-1:0] a_in,
    input  logic [BW-1:0] b_in,
    output logic          swal_nx,
    output logic          wide_nx,
    output logic          end_cyc,
    output logic          idle,
    output logic [AW-1:0] a_left,
    output logic [BW-1:0] b_left
);
    phase_e        ph_q;
    logic          wide_q;
    logic          load;
    logic [AW-1:0] a_nxt;
    logic [BW-1:0] b_eff;

    assign b_eff   = (b_in < BW'(B_FLOOR)) ? BW'(B_FLOOR) : b_in;
    assign idle    = (ph_q == PH_IDLE);
    assign end_cyc = !idle && tc && (b_left == BW'(1));
    assign load    = idle || end_cyc;

    always_comb begin
        if (load) begin
            a_nxt = a_in;
        end else if (a_left != '0) begin
            a_nxt = a_left - AW'(1);
        end else begin
            a_nxt = '0;
        end
    end

    assign swal_nx = (a_nxt != '0);
    assign wide_nx = load ? mod_sel : wide_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            ph_q   <= PH_IDLE;
            a_left <= '0;
            b_left <= '0;
            wide_q <= 1'b0;
        end else if (adv && tc) begin
            if (load) begin
                ph_q   <= PH_RUN;
                b_left <= b_eff;
                wide_q <= mod_sel;
            end else begin
                b_left <= b_left - BW'(1);
            end
            a_left <= a_nxt;
        end
    end

endmodule

// File: rtl/swallow_div.sv
module swallow_div
    import swdiv_pkg::*;
#(
    parameter int PRE_LOG2 = PRE_LOG2_DEF,
    parameter int A_IN_W   = A_PORT_BITS,
    parameter int B_W      = B_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mod_sel,
    input  logic [A_IN_W-1:0] a_preset,
    input  logic [B_W-1:0]    b_preset,
    input  logic              pwr_dn,
    input  logic              cnt_clr,
    output logic              fp
);
    localparam int A_W = PRE_LOG2 + 1;
    localparam logic [A_IN_W-1:0] A_MASK = A_IN_W'((1 << A_W) - 1);

    logic              clr;
    logic              adv;
    logic              tc;
    logic              swal_nx;
    logic              wide_nx;
    logic              end_cyc;
    logic              idle;
    logic [A_IN_W-1:0] a_left;
    logic [B_W-1:0]    b_left;
    logic [A_IN_W-1:0] a_eff;
    logic              fp_q;

    assign clr   = rst || cnt_clr;
    assign adv   = !pwr_dn;
    assign a_eff = a_preset & A_MASK;

    swdiv_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
        .clk     (clk),
        .clr     (clr),
        .adv     (adv),
        .wide_nx (wide_nx),
        .swal_nx (swal_nx),
        .tc      (tc)
    );

    swdiv_counters #(.AW(A_IN_W), .BW(B_W)) u_cnt (
        .clk     (clk),
        .clr     (clr),
        .adv     (adv),
        .tc      (tc),
        .mod_sel (mod_sel),
        .a_in    (a_eff),
        .b_in    (b_preset),
        .swal_nx (swal_nx),
        .wide_nx (wide_nx),
        .end_cyc (end_cyc),
        .idle    (idle),
        .a_left  (a_left),
        .b_left  (b_left)
    );

    always_ff @(posedge clk) begin
        if (clr) begin
            fp_q <= 1'b0;
        end else begin
            fp_q <= adv && end_cyc;
        end
    end

    assign fp = fp_q;

endmodule

// File: rtl/swdiv_chk.sv
module swdiv_chk #(
    parameter int AW = 7,
    parameter int BW = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          pwr_dn,
    input logic          cnt_clr,
    input logic          fp,
    input logic          idle,
    input logic          end_cyc,
    input logic [AW-1:0] a_left,
    input logic [BW-1:0] b_left
);
    // R5
    a_r5_one_wide: assert property (@(posedge clk) disable iff (rst)
        fp |=> !fp);

    // R8
    a_r8_pd_silent: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> !fp);

    // R8
    a_r8_pd_hold: assert property (@(posedge clk) disable iff (rst)
        (pwr_dn && !cnt_clr) |=> ($stable(a_left) && $stable(b_left) && $stable(idle)));

    // R9
    a_r9_clr_idle: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (idle && !fp));

    // R4
    a_r4_b_nonzero: assert property (@(posedge clk) disable iff (rst)
        !idle |-> (b_left != '0));

    // R1
    a_r1_swallow_done: assert property (@(posedge clk) disable iff (rst)
        (!pwr_dn && !idle && (a_left == '0) && !end_cyc) |=> (a_left == '0));

endmodule

bind swallow_div swdiv_chk #(.AW(A_IN_W), .BW(B_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pwr_dn  (pwr_dn),
    .cnt_clr (cnt_clr),
    .fp      (fp),
    .idle    (idle),
    .end_cyc (end_cyc),
    .a_left  (a_left),
    .b_left  (b_left)
);

// File: tb/tb_swallow_div.sv
`timescale 1ns/1ps
module tb_swallow_div;

    localparam int NV    = 10;
    localparam int LIMIT = 10000;

    // {mod_sel, a, b, expected N}
    localparam logic [34:0] VECS [0:NV-1] = '{
        {1'b0, 7'd0,  11'd3,  16'd96},    // R1 minimum
        {1'b0, 7'd3,  11'd3,  16'd99},    // R1 A equal to B
        {1'b0, 7'd5,  11'd10, 16'd325},   // R1
        {1'b1, 7'd0,  11'd4,  16'd256},   // R2 wide pair
        {1'b1, 7'd63, 11'd63, 16'd4095},  // R2 largest swallow
        {1'b1, 7'd7,  11'd12, 16'd775},   // R2
        {1'b0, 7'h45, 11'd8,  16'd261},   // R3 bit 6 ignored
        {1'b0, 7'd0,  11'd1,  16'd96},    // R4 B=1
        {1'b1, 7'd2,  11'd0,  16'd194},   // R4 B=0
        {1'b0, 7'd31, 11'd31, 16'd1023}   // R1
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mod_sel = 1'b0;
    logic [6:0]  a_preset = 7'd0;
    logic [10:0] b_preset = 11'd3;
    logic        pwr_dn = 1'b0;
    logic        cnt_clr = 1'b0;
    logic        fp;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    swallow_div dut (
        .clk      (clk),
        .rst      (rst),
        .mod_sel  (mod_sel),
        .a_preset (a_preset),
        .b_preset (b_preset),
        .pwr_dn   (pwr_dn),
        .cnt_clr  (cnt_clr),
        .fp       (fp)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Counts falling edges until fp is seen high.
    task automatic measure(output int gap);
        int g;
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!fp && g < LIMIT);
        gap = g;
    endtask

    task automatic restart(input logic w, input logic [6:0] a, input logic [10:0] b);
        @(negedge clk);
        mod_sel  = w;
        a_preset = a;
        b_preset = b;
        cnt_clr  = 1'b1;
        repeat (2) @(negedge clk);
        cnt_clr  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int g;
        int low_seen;

        // R10: reset state
        low_seen = 0;
        repeat (5) begin
            @(negedge clk);
            if (!fp) low_seen++;
        end
        check(low_seen == 5, "R10 fp low in reset", low_seen, 5);
        rst = 1'b0;

        // Vector table walk: R1 R2 R3 R4 R7
        for (int i = 0; i < NV; i++) begin
            int n;
            n = int'(VECS[i][15:0]);
            restart(VECS[i][34], VECS[i][33:27], VECS[i][26:16]);
            measure(g);
            check(g == n + 1, $sformatf("R7 first pulse vec%0d", i), g, n + 1);
            measure(g);
            check(g == n, $sformatf("R1 period vec%0d", i), g, n);
            measure(g);
            check(g == n, $sformatf("R1 second period vec%0d", i), g, n);
        end

        // R6: rewrite presets mid-cycle, old length holds once
        restart(1'b0, 7'd0, 11'd3);
        measure(g);
        mod_sel  = 1'b1;
        b_preset = 11'd4;
        a_preset = 7'd0;
        measure(g);
        check(g == 96, "R6 old period kept", g, 96);
        measure(g);
        check(g == 256, "R6 new period applied", g, 256);
        // change inside a cycle, a few clocks after the pulse
        repeat (7) @(negedge clk);
        b_preset = 11'd5;
        measure(g);
        check(g == 256 - 7, "R6 mid-cycle write ignored", g, 249);
        measure(g);
        check(g == 320, "R6 later cycle uses new B", g, 320);
        b_preset = 11'd4;
        measure(g);

        // R5: pulse is one clock wide
        @(negedge clk);
        check(fp == 1'b0, "R5 pulse width", int'(fp), 0);
        measure(g);
        check(g == 255, "R5 spacing after width check", g, 255);

        // R8: power-down freeze of 25 clocks
        g = 0;
        repeat (10) begin @(negedge clk); g++; end
        pwr_dn = 1'b1;
        low_seen = 0;
        repeat (25) begin
            @(negedge clk);
            g++;
            if (!fp) low_seen++;
        end
        pwr_dn = 1'b0;
        check(low_seen == 25, "R8 fp low in power-down", low_seen, 25);
        begin
            int rest;
            measure(rest);
            g = g + rest;
        end
        check(g == 256 + 25, "R8 stretched period", g, 281);
        measure(g);
        check(g == 256, "R8 period after resume", g, 256);

        // R9: clear mid-cycle
        repeat (30) @(negedge clk);
        cnt_clr = 1'b1;
        low_seen = 0;
        repeat (4) begin
            @(negedge clk);
            if (!fp) low_seen++;
        end
        cnt_clr = 1'b0;
        check(low_seen == 4, "R9 fp low in clear", low_seen, 4);
        measure(g);
        check(g == 257, "R9 restart after clear", g, 257);

        // R10: reset mid-run, then R7 restart
        repeat (40) @(negedge clk);
        rst = 1'b1;
        low_seen = 0;
        repeat (3) begin
            @(negedge clk);
            if (!fp) low_seen++;
        end
        rst = 1'b0;
        check(low_seen == 3, "R10 fp low in mid-run reset", low_seen, 3);
        measure(g);
        check(g == 257, "R7 restart after reset", g, 257);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule